// File: doc/BRIEF.md
# Sixteen-Bit Carry-Skip Adder

This block adds two unsigned 16-bit operands and a one-bit carry-in. It returns a 16-bit sum and a carry-out. The operand bits are cut into equal slices of four. Each slice is a short ripple chain of full adders. Every full adder first forms a propagate term (the XOR of its two operand bits) and a generate term (their AND). It then produces its sum bit as propagate XOR incoming carry, and its carry as generate OR (propagate AND incoming carry).

When all four propagate terms of a slice are high, that slice would only pass its incoming carry straight through. A 2:1 selector therefore hands the slice's carry-in directly to the next slice and does not wait for the ripple. The topmost slice has no selector, so the block's carry-out is always that slice's ripple result.

The block is purely combinational. The house style's registered outputs and reset do not apply to it. It is meant to sit inside a datapath where the surrounding registers set the timing.

Top module: `carry_skip_adder`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin.
- R2: When every bit pair differs (b equal to the bitwise inverse of a), the sum is all ones and cout is 0 if cin is 0. If cin is 1, the sum is all zeros and cout is 1.
- R3: A slice whose four bit pairs all differ passes its incoming carry unchanged as the carry into the next slice. Slices are bits [3:0], [7:4], [11:8] and [15:12]. A carry generated in a low slice therefore reaches the next slice above any run of such slices.
- R4: A carry generated inside the top slice (bits [15:12]) appears on cout, even when all lower bits and cin are zero. For example, a = b = 0x8000 gives sum 0x0000 and cout 1.
- R5: When no bit position has both operand bits set and cin is 0, no carry forms: sum equals a OR b and cout is 0.
- R6: With both operands all ones and cin = 1, the sum is 0xFFFF and cout is 1.
- R7: A slice whose incoming carry is 1 and whose bits all generate (both operand bits 1) produces a carry-out of 1. With cin = 1 and a = b = 0x000F, the sum is 0x001F and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15, taken from the top slice's ripple chain |

## Verification
The bench targets full-propagate patterns, where the skip selectors alone must move a carry across slices. If a selector picked the wrong input, or if the group-propagate AND missed a bit, the carry would be lost or doubled: the sum would then be off by a power of sixteen, or cout would be wrong.

Carries generated inside the top slice are driven separately. A design that wrongly put a skip selector on the top slice, or that dropped its ripple output, would lose cout in that case.

Patterns with no carries at all, and all-ones operands, catch swapped propagate and generate terms. Seeded random vectors then cover mixed chains in which some slices skip and others ripple.

// File: rtl/cba_pkg.sv
package cba_pkg;
  localparam int ADD_WIDTH = 16;
  localparam int SLICE_WIDTH = 4;
endpackage

// File: rtl/cba_fa.sv
module cba_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic p,
  output logic s,
  output logic co
);
  logic g;
  always_comb begin
    p  = a ^ b;
    g  = a & b;
    s  = p ^ ci;
    co = g | (p & ci);
  end
endmodule

// File: rtl/cba_slice.sv
module cba_slice #(
  parameter int SW       = 4,
  parameter int HAS_SKIP = 1
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] sum,
  output logic          cout,
  output logic          bypass
);
  logic [SW:0]   chain;
  logic [SW-1:0] prop;

  assign chain[0] = cin;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    cba_fa u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(chain[i]),
      .p (prop[i]),
      .s (sum[i]),
      .co(chain[i+1])
    );
  end

  assign bypass = &prop;

  if (HAS_SKIP != 0) begin : g_skip
    assign cout = bypass ? cin : chain[SW];
  end else begin : g_noskip
    assign cout = chain[SW];
  end
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int WIDTH = cba_pkg::ADD_WIDTH,
  parameter int GROUP = cba_pkg::SLICE_WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSLICE = WIDTH / GROUP;

  logic [NSLICE:0]   slice_carry;
  logic [NSLICE-1:0] slice_bp;

  assign slice_carry[0] = cin;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    cba_slice #(
      .SW      (GROUP),
      .HAS_SKIP((g < NSLICE - 1) ? 1 : 0)
    ) u_slice (
      .a     (a[g*GROUP +: GROUP]),
      .b     (b[g*GROUP +: GROUP]),
      .cin   (slice_carry[g]),
      .sum   (sum[g*GROUP +: GROUP]),
      .cout  (slice_carry[g+1]),
      .bypass(slice_bp[g])
    );
  end

  assign cout = slice_carry[NSLICE];
endmodule

// File: rtl/cba_checker.sv
module cba_checker #(
  parameter int W = 16,
  parameter int G = 4
) (
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           cin,
  input logic [W-1:0]   sum,
  input logic           cout,
  input logic [W/G:0]   sc,
  input logic [W/G-1:0] bp
);
  localparam int NS = W / G;

  logic [W:0] ref_total;
  logic       known;

  always_comb begin
    known     = !$isunknown({a, b, cin});
    ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    if (known) begin
      a_r1_exact_sum: assert ({cout, sum} == ref_total)
        else $error("R1 sum mismatch");
      if ((a ^ b) == {W{1'b1}}) begin
        a_r2_full_prop: assert (cout == cin && sum == (cin ? {W{1'b0}} : {W{1'b1}}))
          else $error("R2 full propagate wrong");
      end
      if (((a & b) == '0) && !cin) begin
        a_r5_no_carry: assert (sum == (a | b) && !cout)
          else $error("R5 spurious carry");
      end
      for (int g = 0; g < NS; g++) begin
        if (bp[g]) begin
          a_r3_skip_pass: assert (sc[g+1] == sc[g])
            else $error("R3 skipped slice altered carry");
        end
      end
    end
  end
endmodule

bind carry_skip_adder cba_checker #(.W(WIDTH), .G(GROUP)) u_chk (
  .a   (a),
  .b   (b),
  .cin (cin),
  .sum (sum),
  .cout(cout),
  .sc  (slice_carry),
  .bp  (slice_bp)
);

// File: tb/sim_carry_skip_adder.sv
module sim_carry_skip_adder;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  carry_skip_adder u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  function automatic logic [16:0] expect_sum(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input logic [16:0] exp_v, input string tag);
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
    total++;
    if ({cout, sum} !== exp_v) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", tag, x, y, c, {cout, sum}, exp_v);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    #15000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    apply(16'h0000, 16'h0000, 1'b0, 17'h00000, "R1 zero inputs");
    apply(16'hA5A5, 16'h5A5A, 1'b0, 17'h0FFFF, "R2 full propagate cin0");
    apply(16'hA5A5, 16'h5A5A, 1'b1, 17'h10000, "R2 full propagate cin1");
    apply(16'h0000, 16'hFFFF, 1'b1, 17'h10000, "R2 zero plus ones cin1");
    apply(16'h0F0F, 16'hF0F0, 1'b1, 17'h10000, "R2 alternating nibbles");
    apply(16'h0FF1, 16'h000F, 1'b0, 17'h01000, "R3 carry skips two slices");
    apply(16'hFFF1, 16'h000F, 1'b0, 17'h10000, "R3 carry skips into cout");
    apply(16'h00F0, 16'h0F10, 1'b0, 17'h01000, "R3 middle slice skip");
    apply(16'h8000, 16'h8000, 1'b0, 17'h10000, "R4 top slice generate");
    apply(16'hF000, 16'h1000, 1'b0, 17'h10000, "R4 top slice ripple");
    apply(16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF, "R5 alternating no carry");
    apply(16'h1234, 16'h4008, 1'b0, 17'h0523C, "R5 disjoint bits");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R6 all ones cin1");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE, "R6 all ones cin0");
    apply(16'h000F, 16'h000F, 1'b1, 17'h0001F, "R7 slice generate with cin");
    apply(16'h0F0F, 16'h0F0F, 1'b1, 17'h01E1F, "R7 two generating slices");
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] x, y;
      logic        c;
      x = 16'($urandom);
      y = 16'($urandom);
      c = 1'($urandom);
      if (n % 4 == 1) y = ~x ^ (16'h1 << (n % 16));
      if (n % 4 == 2) y = ~x;
      apply(x, y, c, expect_sum(x, y, c), "R1 random");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule